// File: doc/BRIEF.md
# DDR Read-Capture Leveling Engine

This block tunes the read-capture path of a DDR3 PHY after the memory has been initialised. It handles the byte lanes strictly one after another. For each lane it runs two nested loops. The outer loop walks every bitslip setting and the inner loop walks every read-delay tap. At each (bitslip, tap) point it reprograms the PHY with the pause strobe held around the change. It then waits for the capture logic to settle and asks an external pattern tester for one write-then-read check.

A check counts as a pass only when the tester reports good data and the PHY's burst-detect input was seen during that check. For each bitslip the engine tracks the lowest and highest passing taps. A bitslip's score is the span of those taps. The highest score wins, and a tie goes to the lower bitslip. The lane is then programmed with the midpoint tap of the winning window. A lane with no passing point is flagged, left at tap 0 and bitslip 0, and the engine moves on to the next lane.

The test port uses valid/ready. The engine raises `req_valid` and holds it, with the PHY settings frozen, until the tester takes the request with `req_ready`. The tester may stall for any number of cycles. The engine raises `rsp_ready` only while it is waiting for a result, and the result is taken on the cycle where `rsp_valid` and `rsp_ready` are both high. Only one check is outstanding at a time.

Top module: `rdlvl_engine`

## Requirements
- R1: After reset, `done`, `phy_pause`, `req_valid` and `rsp_ready` are 0 and every result output is 0. `start` is acted on only while the engine is idle; a `start` pulse during a calibration has no effect on the test sequence.
- R2: Lanes are calibrated in ascending order. Within a lane, bitslip runs 0..SLIPS-1 as the outer loop and tap runs 0..TAPS-1 as the inner loop. Every accepted request carries the point under test on `phy_lane`, `phy_bitslip` and `phy_delay`.
- R3: A point passes only when the result has `rsp_pass`=1 and `burst_det` was 1 in at least one cycle after the request was accepted, up to and including the cycle the result is taken.
- R4: A bitslip's score is (highest passing tap − lowest passing tap + 1). It counts only when that bitslip has a passing tap. The bitslip with the strictly highest score wins, so ties go to the lower bitslip value.
- R5: The final tap of a lane is floor((low + high) / 2) of the winning bitslip's window. The engine drives it, together with the winning bitslip, to the PHY before the lane's result is stored.
- R6: A lane with no passing point gets its bit in `res_err` set to 1 and a final tap and bitslip of 0. Calibration then continues with the next lane.
- R7: Whenever `phy_lane`, `phy_delay` or `phy_bitslip` changes, `phy_pause` has been 1 for PAUSE_CYC+1 cycles before the change. It stays 1 in the first PAUSE_CYC cycles that show the new value.
- R8: `req_valid` never rises before `phy_pause` has been 0 for at least SETTLE_CYC consecutive cycles, and it is never 1 while `phy_pause` is 1.
- R9: Once `req_valid` is 1, it stays 1 with the PHY outputs unchanged until `req_ready` takes the request. `rsp_ready` is 1 only while a result is awaited, and it drops after a result is taken.
- R10: `done` is a one-cycle pulse that follows the last lane's result. Results are held unchanged while idle and are cleared to 0 when a new `start` is taken.
- R11: Lane i's final tap is at `res_delay[i*TAP_W +: TAP_W]`, its bitslip at `res_bitslip[i*SLIP_W +: SLIP_W]`, and its error flag at `res_err[i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a calibration (taken when idle) |
| done | output | 1 | One-cycle completion pulse |
| phy_lane | output | LANE_W | Byte lane the PHY settings apply to |
| phy_delay | output | TAP_W | Read-delay tap driven to the PHY |
| phy_bitslip | output | SLIP_W | Bitslip driven to the PHY |
| phy_pause | output | 1 | Pause strobe held around every settings change |
| burst_det | input | 1 | Burst-detect indication from the PHY |
| req_valid | output | 1 | Pattern-check request valid |
| req_ready | input | 1 | Tester accepts the request |
| rsp_valid | input | 1 | Tester result valid |
| rsp_pass | input | 1 | Tester saw correct data |
| rsp_ready | output | 1 | Engine is waiting for a result |
| res_delay | output | LANES*TAP_W | Final tap per lane |
| res_bitslip | output | LANES*SLIP_W | Final bitslip per lane |
| res_err | output | LANES | Per-lane no-window flag |

## Verification
The bench's tester presents a pass map in which two bitslips tie on score; a design that breaks ties upward, or replaces the winner on equal scores, programs the wrong bitslip. Another map has a window with a gap in it that must still outscore a wider contiguous run, because the score is the span. Another lane reports good data while burst-detect stays low; a design that ignores burst-detect would wrongly choose that lane's window. One lane has no passing point at all, so the error flag and the zero fallback must appear without stalling the next lane. Request back-pressure, a `start` pulse in the middle of a run, and the pause/settle timing around every settings change are checked on each clock, which exposes a shortened pause or a setting that moves while a request is pending.

// File: rtl/rdlvl_pkg.sv
package rdlvl_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PRE,
    ST_APPLY,
    ST_POST,
    ST_SETTLE,
    ST_REQ,
    ST_WAIT,
    ST_EVAL,
    ST_CLOSE,
    ST_COMMIT,
    ST_DONE
  } rdlvl_state_e;
endpackage

// File: rtl/rdlvl_hold_timer.sv
module rdlvl_hold_timer #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

  // R7/R8: pause and settle windows shrink by exactly one per cycle
  p_count_down_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/rdlvl_window_trk.sv
module rdlvl_window_trk #(
  parameter int TAP_W  = 3,
  parameter int SLIP_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lane_clr,
  input  logic              hit_en,
  input  logic              hit_pass,
  input  logic [TAP_W-1:0]  hit_tap,
  input  logic              close_en,
  input  logic [SLIP_W-1:0] close_slip,
  output logic              best_any,
  output logic [SLIP_W-1:0] best_slip,
  output logic [TAP_W-1:0]  best_mid
);
  logic             cur_any;
  logic [TAP_W-1:0] cur_lo, cur_hi;
  logic [TAP_W-1:0] best_lo, best_hi;
  logic [TAP_W:0]   best_score, cur_score, mid_sum;
  logic             take;

  assign cur_score = {1'b0, cur_hi} - {1'b0, cur_lo} + (TAP_W+1)'(1);
  assign take      = cur_any && (!best_any || cur_score > best_score);
  assign mid_sum   = {1'b0, best_lo} + {1'b0, best_hi};
  assign best_mid  = mid_sum[TAP_W:1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_any <= 1'b0; cur_lo <= '0; cur_hi <= '0;
      best_any <= 1'b0; best_slip <= '0; best_lo <= '0; best_hi <= '0;
      best_score <= '0;
    end else if (lane_clr) begin
      cur_any <= 1'b0; cur_lo <= '0; cur_hi <= '0;
      best_any <= 1'b0; best_slip <= '0; best_lo <= '0; best_hi <= '0;
      best_score <= '0;
    end else if (close_en) begin
      if (take) begin
        best_any   <= 1'b1;
        best_slip  <= close_slip;
        best_lo    <= cur_lo;
        best_hi    <= cur_hi;
        best_score <= cur_score;
      end
      cur_any <= 1'b0;
    end else if (hit_en && hit_pass) begin
      if (!cur_any) cur_lo <= hit_tap;
      cur_hi  <= hit_tap;
      cur_any <= 1'b1;
    end
  end

  // R4: a recorded window is never inverted
  p_win_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
    best_any |-> (best_lo <= best_hi));
  // R2: taps arrive in ascending order within a bitslip
  p_tap_ascend_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_en && hit_pass && cur_any) |-> (hit_tap > cur_hi));
endmodule

// File: rtl/rdlvl_engine.sv
module rdlvl_engine
  import rdlvl_pkg::*;
#(
  parameter int LANES      = 2,
  parameter int TAPS       = 8,
  parameter int SLIPS      = 4,
  parameter int PAUSE_CYC  = 4,
  parameter int SETTLE_CYC = 2,
  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int TAP_W  = (TAPS  > 1) ? $clog2(TAPS)  : 1,
  localparam int SLIP_W = (SLIPS > 1) ? $clog2(SLIPS) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  output logic                     done,
  output logic [LANE_W-1:0]        phy_lane,
  output logic [TAP_W-1:0]         phy_delay,
  output logic [SLIP_W-1:0]        phy_bitslip,
  output logic                     phy_pause,
  input  logic                     burst_det,
  output logic                     req_valid,
  input  logic                     req_ready,
  input  logic                     rsp_valid,
  input  logic                     rsp_pass,
  output logic                     rsp_ready,
  output logic [LANES*TAP_W-1:0]   res_delay,
  output logic [LANES*SLIP_W-1:0]  res_bitslip,
  output logic [LANES-1:0]         res_err
);
  localparam int TMAX = (PAUSE_CYC > SETTLE_CYC) ? PAUSE_CYC : SETTLE_CYC;
  localparam int CW   = $clog2(TMAX + 1);
  localparam logic [CW-1:0]     PRE_LD    = CW'(PAUSE_CYC - 1);
  localparam logic [CW-1:0]     SET_LD    = CW'(SETTLE_CYC - 1);
  localparam logic [TAP_W-1:0]  TAP_LAST  = TAP_W'(TAPS - 1);
  localparam logic [SLIP_W-1:0] SLIP_LAST = SLIP_W'(SLIPS - 1);
  localparam logic [LANE_W-1:0] LANE_LAST = LANE_W'(LANES - 1);

  rdlvl_state_e      state;
  logic [LANE_W-1:0] lane;
  logic [TAP_W-1:0]  tap;
  logic [SLIP_W-1:0] slip;
  logic              final_ph, burst_seen, pass_q;
  logic              tmr_load, tmr_exp, enter_pre, enter_settle;
  logic              res_clr, commit;
  logic              trk_any;
  logic [SLIP_W-1:0] trk_slip;
  logic [TAP_W-1:0]  trk_mid;

  assign done      = (state == ST_DONE);
  assign req_valid = (state == ST_REQ);
  assign rsp_ready = (state == ST_WAIT);
  assign phy_pause = (state == ST_PRE) || (state == ST_APPLY) || (state == ST_POST);
  assign res_clr   = (state == ST_IDLE) && start;
  assign commit    = (state == ST_COMMIT);

  always_comb begin
    enter_pre = res_clr
             || ((state == ST_EVAL) && (tap != TAP_LAST))
             || (state == ST_CLOSE)
             || (commit && (lane != LANE_LAST));
    enter_settle = (state == ST_POST) && tmr_exp && !final_ph;
    tmr_load = enter_pre || enter_settle || (state == ST_APPLY);
  end

  rdlvl_hold_timer #(.CW(CW)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (enter_settle ? SET_LD : PRE_LD),
    .expired  (tmr_exp)
  );

  rdlvl_window_trk #(.TAP_W(TAP_W), .SLIP_W(SLIP_W)) u_trk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lane_clr   (res_clr || commit),
    .hit_en     (state == ST_EVAL),
    .hit_pass   (pass_q),
    .hit_tap    (tap),
    .close_en   (state == ST_CLOSE),
    .close_slip (slip),
    .best_any   (trk_any),
    .best_slip  (trk_slip),
    .best_mid   (trk_mid)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      lane <= '0; tap <= '0; slip <= '0;
      final_ph <= 1'b0; burst_seen <= 1'b0; pass_q <= 1'b0;
      phy_lane <= '0; phy_delay <= '0; phy_bitslip <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          lane <= '0; tap <= '0; slip <= '0; final_ph <= 1'b0;
          state <= ST_PRE;
        end
        ST_PRE:  if (tmr_exp) state <= ST_APPLY;
        ST_APPLY: begin
          phy_lane <= lane;
          if (!final_ph) begin
            phy_delay   <= tap;
            phy_bitslip <= slip;
          end else if (trk_any) begin
            phy_delay   <= trk_mid;
            phy_bitslip <= trk_slip;
          end else begin
            phy_delay   <= '0;
            phy_bitslip <= '0;
          end
          state <= ST_POST;
        end
        ST_POST:   if (tmr_exp) state <= final_ph ? ST_COMMIT : ST_SETTLE;
        ST_SETTLE: if (tmr_exp) state <= ST_REQ;
        ST_REQ: if (req_ready) begin
          burst_seen <= 1'b0;
          state <= ST_WAIT;
        end
        ST_WAIT: begin
          if (burst_det) burst_seen <= 1'b1;
          if (rsp_valid) begin
            pass_q <= rsp_pass && (burst_seen || burst_det);
            state  <= ST_EVAL;
          end
        end
        ST_EVAL: begin
          if (tap == TAP_LAST) begin
            tap <= '0;
            state <= ST_CLOSE;
          end else begin
            tap <= tap + 1'b1;
            state <= ST_PRE;
          end
        end
        ST_CLOSE: begin
          if (slip == SLIP_LAST) begin
            slip <= '0;
            final_ph <= 1'b1;
          end else begin
            slip <= slip + 1'b1;
          end
          state <= ST_PRE;
        end
        ST_COMMIT: begin
          final_ph <= 1'b0;
          if (lane == LANE_LAST) state <= ST_DONE;
          else begin
            lane <= lane + 1'b1;
            state <= ST_PRE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_res
    logic [TAP_W-1:0]  d_q;
    logic [SLIP_W-1:0] s_q;
    logic              e_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        d_q <= '0; s_q <= '0; e_q <= 1'b0;
      end else if (res_clr) begin
        d_q <= '0; s_q <= '0; e_q <= 1'b0;
      end else if (commit && (lane == LANE_W'(g))) begin
        d_q <= phy_delay;
        s_q <= phy_bitslip;
        e_q <= !trk_any;
      end
    end
    assign res_delay[g*TAP_W +: TAP_W]     = d_q;
    assign res_bitslip[g*SLIP_W +: SLIP_W] = s_q;
    assign res_err[g]                      = e_q;
  end

  // R7: any PHY setting change happens inside a pause window
  p_change_paused_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (phy_delay != $past(phy_delay) || phy_bitslip != $past(phy_bitslip) ||
     phy_lane != $past(phy_lane))
    |-> (phy_pause && $past(phy_pause) && $past(phy_pause, 2)));
  // R8: a request only follows a released pause
  p_settle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid) |-> !$past(phy_pause));
  // R9: a pending request holds with frozen settings
  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(phy_delay) &&
                                   $stable(phy_bitslip) && $stable(phy_lane)));
  // R9: result acceptance ends the wait
  p_rsp_take_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_ready && rsp_valid) |=> !rsp_ready);
  // R3: no burst seen means no pass
  p_burst_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_ready && rsp_valid && !burst_seen && !burst_det) |=> !pass_q);
  // R10: done is a single-cycle pulse and results hold while idle
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_res_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && !start) |=> ($stable(res_delay) && $stable(res_bitslip) &&
                                      $stable(res_err)));
endmodule

// File: tb/sim_rdlvl_engine.sv
module sim_rdlvl_engine;
  localparam int LN = 2, TP = 8, SL = 4, PC = 4, SC = 2;
  localparam int LW = 1, TW = 3, SW = 2;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic done, phy_pause, req_valid, rsp_ready;
  logic [LW-1:0] phy_lane;
  logic [TW-1:0] phy_delay;
  logic [SW-1:0] phy_bitslip;
  logic burst_det = 1'b0, req_ready = 1'b0, rsp_valid = 1'b0, rsp_pass = 1'b0;
  logic [LN*TW-1:0] res_delay;
  logic [LN*SW-1:0] res_bitslip;
  logic [LN-1:0]    res_err;

  rdlvl_engine #(.LANES(LN), .TAPS(TP), .SLIPS(SL), .PAUSE_CYC(PC), .SETTLE_CYC(SC)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done),
    .phy_lane(phy_lane), .phy_delay(phy_delay), .phy_bitslip(phy_bitslip),
    .phy_pause(phy_pause), .burst_det(burst_det),
    .req_valid(req_valid), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_pass(rsp_pass), .rsp_ready(rsp_ready),
    .res_delay(res_delay), .res_bitslip(res_bitslip), .res_err(res_err));

  initial forever #4 clk = ~clk;

  int nvec = 0, nfail = 0, scen = 0, done_cnt = 0;
  bit finished = 0;
  int exp_q[$];
  int e_del[LN], e_sl[LN], e_err[LN];

  task automatic chk(input string tag, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Tester pass map (rsp_pass) per scenario, lane, bitslip, tap
  function automatic bit pt_ok(int sc, int ln, int sl, int tp);
    case (sc)
      0: return (ln == 0) ? (sl == 1 && tp >= 2 && tp <= 4)
                          : (sl == 2 || (sl == 3 && tp == 7));
      1: return (ln == 0) ? ((sl == 0 && tp >= 5 && tp <= 6) || (sl == 3 && tp >= 1 && tp <= 2))
                          : ((sl == 1 && tp >= 3 && tp <= 5) || (sl == 3 && tp == 6));
      default: return (ln == 0) ? 1'b0
                          : ((sl == 1 && tp <= 3) || (sl == 2 && (tp == 1 || tp == 5)));
    endcase
  endfunction
  function automatic bit burst_on(int sc, int ln, int sl);
    return !(sc == 1 && ln == 1 && sl == 1);
  endfunction

  task automatic plan(input int sc);
    exp_q.delete();
    for (int ln = 0; ln < LN; ln++) begin
      int bscore = 0;
      e_del[ln] = 0; e_sl[ln] = 0; e_err[ln] = 1;
      for (int sl = 0; sl < SL; sl++) begin
        int mn = -1, mx = -1;
        for (int tp = 0; tp < TP; tp++) begin
          exp_q.push_back(ln * 10000 + sl * 100 + tp);
          if (pt_ok(sc, ln, sl, tp) && burst_on(sc, ln, sl)) begin
            if (mn < 0) mn = tp;
            mx = tp;
          end
        end
        if (mn >= 0 && (mx - mn + 1) > bscore) begin
          bscore = mx - mn + 1;
          e_sl[ln] = sl; e_del[ln] = (mn + mx) / 2; e_err[ln] = 0;
        end
      end
    end
  endtask

  // Per-clock reference checks and tester model
  int hi_run = 0, lo_run = 0, post_left = 0, acc_cnt = 0, rdy_wait = 0;
  int resp_cnt = 0, resp_len = 0;
  bit resp_active = 0, pok = 0, bon = 0, have_prev = 0;
  logic p_rv = 0, p_rr = 0, p_done = 0;
  logic [LW-1:0] p_lane; logic [TW-1:0] p_del; logic [SW-1:0] p_sl;

  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        bit req_acc, rsp_acc;
        req_acc = p_rv && req_ready;
        rsp_acc = rsp_valid && p_rr;
        if (have_prev && (phy_lane != p_lane || phy_delay != p_del || phy_bitslip != p_sl)) begin
          chk("R7 pause run before change", int'(phy_pause && hi_run >= PC + 1), 1);
          post_left = PC;
        end
        if (post_left > 0) begin
          chk("R7 pause held after change", int'(phy_pause), 1);
          post_left--;
        end
        if (req_valid && !p_rv) chk("R8 settle before request", int'(lo_run >= SC && !phy_pause), 1);
        if (p_rv && !req_acc)
          chk("R9 request held stable", int'(req_valid && phy_delay == p_del &&
              phy_bitslip == p_sl && phy_lane == p_lane), 1);
        if (p_done) chk("R10 done single cycle", int'(done), 0);
        if (done) done_cnt++;
        if (req_acc) begin
          int code;
          code = int'(p_lane) * 10000 + int'(p_sl) * 100 + int'(p_del);
          if (exp_q.size() == 0) chk("R2 unexpected request", code, -1);
          else chk("R2 request point", code, exp_q.pop_front());
          pok = pt_ok(scen, int'(p_lane), int'(p_sl), int'(p_del));
          bon = burst_on(scen, int'(p_lane), int'(p_sl));
          resp_len = 2 + (acc_cnt % 2); resp_cnt = resp_len; resp_active = 1;
          acc_cnt++;
          req_ready = (acc_cnt % 4 == 0);
          rdy_wait = acc_cnt % 3;
        end else if (req_valid && !req_ready) begin
          if (rdy_wait == 0) req_ready = 1'b1; else rdy_wait--;
        end
        if (rsp_acc) begin
          rsp_valid = 1'b0; resp_active = 0;
        end
        if (resp_active && !rsp_valid) begin
          burst_det = bon && (resp_cnt == resp_len);
          if (resp_cnt == 0) begin rsp_valid = 1'b1; rsp_pass = pok; end
          else resp_cnt--;
        end else burst_det = 1'b0;
        hi_run = phy_pause ? hi_run + 1 : 0;
        lo_run = phy_pause ? 0 : lo_run + 1;
        p_rv = req_valid; p_rr = rsp_ready; p_done = done;
        p_lane = phy_lane; p_del = phy_delay; p_sl = phy_bitslip;
        have_prev = 1;
      end
    end
  end

  task automatic check_results(input int sc);
    chk("R2 all points visited", exp_q.size(), 0);
    for (int ln = 0; ln < LN; ln++) begin
      chk($sformatf("R4 R11 s%0d lane%0d bitslip", sc, ln), int'(res_bitslip[ln*SW +: SW]), e_sl[ln]);
      chk($sformatf("R5 R11 s%0d lane%0d tap", sc, ln), int'(res_delay[ln*TW +: TW]), e_del[ln]);
      chk($sformatf("R6 R11 s%0d lane%0d err", sc, ln), int'(res_err[ln]), e_err[ln]);
    end
    chk("R5 phy tap of last lane", int'(phy_delay), e_del[LN-1]);
    chk("R5 phy bitslip of last lane", int'(phy_bitslip), e_sl[LN-1]);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1 reset state
    chk("R1 done idle", int'(done), 0);
    chk("R1 pause idle", int'(phy_pause), 0);
    chk("R1 req_valid idle", int'(req_valid), 0);
    chk("R1 rsp_ready idle", int'(rsp_ready), 0);
    chk("R1 results zero", int'(res_delay) + int'(res_bitslip) + int'(res_err), 0);
    for (int sc = 0; sc < 3; sc++) begin
      scen = sc;
      plan(sc);
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      // R10 clear on start
      chk("R10 results cleared at start", int'(res_delay) + int'(res_bitslip) + int'(res_err), 0);
      if (sc == 0) begin
        repeat (200) @(negedge clk);
        start = 1'b1;            // R1: ignored while busy
        @(negedge clk); start = 1'b0;
      end
      wait (done_cnt == sc + 1);
      @(negedge clk);
      check_results(sc);
      repeat (20) @(negedge clk);
      chk("R10 results held idle", int'(res_delay), e_del[0] + (e_del[1] << TW));
      chk("R10 no request while idle", int'(req_valid), 0);
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nfail++;
      $display("FAIL R10 watchdog: actual=%0d done pulses expected=%0d", done_cnt, 3);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end
endmodule